// File: doc/BRIEF.md
# Programmable Interval Timer with Modulo Reload

This block is a byte-wide interval timer that sits on a plain CPU register bus. A 16-bit prescaler runs on every cycle of the 4.194304 MHz system clock. A control register picks one of four prescaler taps, and that tap steps an 8-bit counter at 4096, 16384, 65536 or 262144 Hz. When the counter steps past 0xFF, it is loaded with a value that software wrote to a modulo register, and a one-clock interrupt request goes out. With a modulo of M, the interrupt period is (256 - M) ticks.

Software reaches four byte registers: the divider view of the prescaler, the counter, the modulo value and the control byte. Reads are combinational. A write takes effect at the clock edge where the write strobe is sampled. Writing to the divider restarts the prescaler, and this also sets the phase of the counter ticks.

Top module: `ivt_timer`

## Requirements
- R1: After reset the counter, the modulo register and the divider read 0x00, the control register reads 0xF8, and `irq_pulse` is low.
- R2: Offset 4 reads bits 15:8 of a 16-bit prescaler that increments on every clock. A write of any value to offset 4 clears the whole prescaler to zero at that edge.
- R3: Control bits 1:0 choose the tick period, counted in clocks from a prescaler clear: 00 gives 1024, 01 gives 16, 10 gives 64, 11 gives 256. A tick falls on the edge at which the prescaler's low log2(period) bits are all ones.
- R4: While control bit 2 is 0 the counter holds its value. While it is 1 the counter advances on each tick.
- R5: A tick that finds the counter at 0xFF loads the counter with the modulo value. `irq_pulse` is then high for exactly the one clock cycle that follows that edge.
- R6: A tick that finds the counter below 0xFF adds one to it and raises no interrupt.
- R7: A CPU write to the counter at offset 5 on the same edge as a tick takes priority. The counter takes the written byte, and no reload and no interrupt follow from that tick.
- R8: Offsets 5, 6 and 7 are the counter, modulo and control registers, and each reads back what was written. Control bits 7:3 always read as 1. Any other offset reads 0x00, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 4.194304 MHz |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register offset |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_pulse | output | 1 | One-cycle interrupt request on counter overflow |

## Verification
The bench restarts the prescaler before each run. It then predicts the exact clock edge of every interrupt at all four rates, using modulo values that give periods of one tick, four ticks and sixteen ticks. This catches a wrong tap: the interrupts would arrive early or late by a power of two. It also catches a reload from zero instead of the modulo value, because both the spacing and the read-back counter value would be wrong.

A counter write is placed exactly on a pending overflow edge. A design that lets the reload win would show the modulo byte and fire an interrupt. A disabled timer is left idle for hundreds of cycles to catch a counter that drifts. Control read-back and the unmapped offset are probed to catch bits that go missing and writes that leak into a register.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    localparam int DATA_W = 8;
    localparam int PRE_W  = 16;
    localparam int ADDR_W = 4;
    localparam int N_RATE = 4;

    localparam logic [ADDR_W-1:0] OFS_DIV = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] OFS_CNT = ADDR_W'(5);
    localparam logic [ADDR_W-1:0] OFS_MOD = ADDR_W'(6);
    localparam logic [ADDR_W-1:0] OFS_CTL = ADDR_W'(7);

    typedef enum logic [1:0] {
        RATE_DIV1024 = 2'b00,
        RATE_DIV16   = 2'b01,
        RATE_DIV64   = 2'b10,
        RATE_DIV256  = 2'b11
    } rate_e;

    typedef struct packed {
        logic  run;
        rate_e rate;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    // number of low prescaler bits that must all be ones for a tick
    function automatic int tap_bits(input int idx);
        case (idx)
            0:       return 10;
            1:       return 4;
            2:       return 6;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/ivt_prescale.sv
module ivt_prescale #(
    parameter int PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [PRE_W-1:0] pre_q
);

    logic [PRE_W-1:0] pre_d;

    always_comb begin
        pre_d = clr ? '0 : pre_q + PRE_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R2: a clear write restarts the prescaler from zero
    p_div_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pre_q == '0));

    // R2: otherwise the prescaler advances by one each clock
    p_div_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (pre_q == $past(pre_q) + PRE_W'(1)));

endmodule

// File: rtl/ivt_tick_sel.sv
module ivt_tick_sel
    import ivt_pkg::*;
#(
    parameter int PRE_W = 16
) (
    input  logic [PRE_W-1:0] pre,
    input  ctl_t             ctl,
    output logic             tick
);

    logic [N_RATE-1:0] tap_full;

    for (genvar i = 0; i < N_RATE; i++) begin : g_tap
        localparam int K = tap_bits(i);
        assign tap_full[i] = &pre[K-1:0];
    end

    always_comb begin
        tick = ctl.run & tap_full[ctl.rate];
    end

endmodule

// File: rtl/ivt_count.sv
module ivt_count #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_cnt,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] reload,
    output logic [DATA_W-1:0] cnt_q,
    output logic              irq_q
);

    typedef struct packed {
        logic [DATA_W-1:0] cnt;
        logic              irq;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (wr_cnt) begin
            st_d.cnt = wdata;
        end else if (tick) begin
            if (st_q.cnt == '1) begin
                st_d.cnt = reload;
                st_d.irq = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + DATA_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_q = st_q.cnt;
    assign irq_q = st_q.irq;

    // R5: overflow loads the modulo value and raises the request
    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_cnt && cnt_q == '1) |=> (irq_q && cnt_q == $past(reload)));

    // R5: request never lasts two cycles (ticks are at least 16 clocks apart)
    p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);

    // R6: plain tick increments without a request
    p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_cnt && cnt_q != '1) |=> (!irq_q && cnt_q == $past(cnt_q) + DATA_W'(1)));

    // R7: a CPU write beats a coincident tick
    p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (!irq_q && cnt_q == $past(wdata)));

endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
    import ivt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_pulse
);

    localparam int PAD_W = DATA_W - CTL_W;

    typedef struct packed {
        logic [DATA_W-1:0] modulo;
        ctl_t              ctl;
    } regs_t;

    regs_t            regs_d, regs_q;
    logic [PRE_W-1:0] pre;
    logic [DATA_W-1:0] cnt;
    logic             tick;
    logic             wr_div, wr_cnt, wr_mod, wr_ctl;

    always_comb begin
        wr_div = bus_we && (bus_addr == OFS_DIV);
        wr_cnt = bus_we && (bus_addr == OFS_CNT);
        wr_mod = bus_we && (bus_addr == OFS_MOD);
        wr_ctl = bus_we && (bus_addr == OFS_CTL);

        regs_d = regs_q;
        if (wr_mod) regs_d.modulo = bus_wdata;
        if (wr_ctl) regs_d.ctl    = ctl_t'(bus_wdata[CTL_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    ivt_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wr_div),
        .pre_q (pre)
    );

    ivt_tick_sel #(.PRE_W(PRE_W)) u_sel (
        .pre  (pre),
        .ctl  (regs_q.ctl),
        .tick (tick)
    );

    ivt_count #(.DATA_W(DATA_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .wr_cnt (wr_cnt),
        .wdata  (bus_wdata),
        .reload (regs_q.modulo),
        .cnt_q  (cnt),
        .irq_q  (irq_pulse)
    );

    always_comb begin
        case (bus_addr)
            OFS_DIV: bus_rdata = pre[PRE_W-1 -: DATA_W];
            OFS_CNT: bus_rdata = cnt;
            OFS_MOD: bus_rdata = regs_q.modulo;
            OFS_CTL: bus_rdata = {{PAD_W{1'b1}}, regs_q.ctl};
            default: bus_rdata = '0;
        endcase
    end

    // R4: a stopped timer keeps its count unless software writes it
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!regs_q.ctl.run && !wr_cnt) |=> $stable(cnt));

    // R4: no request can appear while stopped
    p_no_irq_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!regs_q.ctl.run && !wr_ctl) |=> !irq_pulse);

    // R8: padding bits of the control byte read as ones
    p_ctl_pad_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_CTL) |-> (bus_rdata[DATA_W-1:CTL_W] == '1));

endmodule

// File: tb/ivt_timer_test.sv
module ivt_timer_test;
    import ivt_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq_pulse;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int exp_q[$];
    bit done = 1'b0;

    ivt_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_pulse (irq_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int got, input int want);
        nchk++;
        if (got !== want) begin
            nfail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h (cycle %0d)", req, got, want, cyc);
        end
    endtask

    // scoreboard monitor: every request must match the next expected edge
    always @(negedge clk) begin
        if (rst_n && irq_pulse) begin
            if (exp_q.size() == 0) begin
                check("R5 unexpected request", cyc, -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                check("R5 request edge", cyc, e);
            end
        end
    end

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d, output int edge_n);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk); #1;
        edge_n = cyc;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output int v);
        @(negedge clk);
        bus_addr = a;
        #1 v = int'(bus_rdata);
    endtask

    task automatic wait_edge(input int e);
        while (cyc < e) begin @(posedge clk); #1; end
    endtask

    // restart prescaler at W, then load counter, modulo and control
    task automatic setup(input logic [7:0] ctl, input logic [7:0] c,
                         input logic [7:0] m, output int w);
        int t;
        wr(OFS_DIV, 8'h00, w);
        wr(OFS_CNT, c, t);
        wr(OFS_MOD, m, t);
        wr(OFS_CTL, ctl, t);
    endtask

    task automatic stop_and_drain(input string req);
        int t;
        wr(OFS_CTL, 8'h00, t);
        check({req, " pending requests"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int w, v, t;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values
        rd(OFS_CNT, v); check("R1 counter", v, 8'h00);
        rd(OFS_MOD, v); check("R1 modulo", v, 8'h00);
        rd(OFS_CTL, v); check("R1 control", v, 8'hF8);
        rd(OFS_DIV, v); check("R1 divider", v, 8'h00);
        check("R1 request", int'(irq_pulse), 0);

        // R2: divider is the upper byte of a cleared prescaler
        wr(OFS_DIV, 8'h5C, w);
        wait_edge(w + 300);  rd(OFS_DIV, v); check("R2 divider at 300", v, 8'h01);
        wait_edge(w + 1000); rd(OFS_DIV, v); check("R2 divider at 1000", v, 8'h03);

        // R8: register read-back and unmapped offset
        wr(OFS_MOD, 8'h5A, t); rd(OFS_MOD, v); check("R8 modulo", v, 8'h5A);
        wr(OFS_CTL, 8'h02, t); rd(OFS_CTL, v); check("R8 control pad", v, 8'hFA);
        wr(OFS_CTL, 8'hFB, t); rd(OFS_CTL, v); check("R8 control full", v, 8'hFB);
        wr(OFS_CTL, 8'h00, t);
        wr(4'h0, 8'h77, t);
        rd(4'h0, v);   check("R8 unmapped read", v, 8'h00);
        rd(OFS_MOD, v); check("R8 unmapped write ignored", v, 8'h5A);

        // R3 R5 R6: 16-clock rate, modulo 0xFC, four-tick period
        setup(8'h05, 8'hFE, 8'hFC, w);
        exp_q.push_back(w + 32); exp_q.push_back(w + 96); exp_q.push_back(w + 160);
        wait_edge(w + 16); rd(OFS_CNT, v); check("R6 increment", v, 8'hFF);
        wait_edge(w + 32); rd(OFS_CNT, v); check("R5 reload value", v, 8'hFC);
        wait_edge(w + 48); rd(OFS_CNT, v); check("R6 after reload", v, 8'hFD);
        wait_edge(w + 170);
        stop_and_drain("R3 rate 01");

        // R3 R5: 64-clock rate, modulo 0xFF, request every tick
        setup(8'h06, 8'hFF, 8'hFF, w);
        exp_q.push_back(w + 64); exp_q.push_back(w + 128); exp_q.push_back(w + 192);
        wait_edge(w + 200);
        stop_and_drain("R3 rate 10");

        // R3 R5: 256-clock rate, modulo 0xF0, sixteen-tick period
        setup(8'h07, 8'hFE, 8'hF0, w);
        exp_q.push_back(w + 512); exp_q.push_back(w + 4608);
        wait_edge(w + 4620);
        stop_and_drain("R3 rate 11");

        // R3 R5: 1024-clock rate, modulo 0x00
        setup(8'h04, 8'hFF, 8'h00, w);
        exp_q.push_back(w + 1024);
        wait_edge(w + 1024); rd(OFS_CNT, v); check("R5 reload zero", v, 8'h00);
        wait_edge(w + 1030);
        stop_and_drain("R3 rate 00");

        // R7: counter write on the overflow edge wins, no request
        setup(8'h05, 8'hFF, 8'h33, w);
        wait_edge(w + 15);
        wr(OFS_CNT, 8'h40, t);
        check("R7 write edge", t, w + 16);
        rd(OFS_CNT, v); check("R7 written value kept", v, 8'h40);
        wait_edge(w + 32); rd(OFS_CNT, v); check("R7 next tick", v, 8'h41);
        wait_edge(w + 40);
        stop_and_drain("R7");

        // R4: disabled timer holds its count
        wr(OFS_CTL, 8'h01, t);
        wr(OFS_CNT, 8'h80, t);
        wait_edge(t + 300);
        rd(OFS_CNT, v); check("R4 hold while stopped", v, 8'h80);
        check("R4 no request while stopped", exp_q.size(), 0);

        repeat (4) @(posedge clk);
        finish_run();
    end

endmodule